// File: doc/BRIEF.md
# Two-Level Lookahead Carry Adder

This block adds two unsigned operands and a carry-in in one combinational pass. The operand is split into equal groups of bits. Inside each group a lookahead generator forms every internal carry as a flat sum of products over the bit generate and propagate terms. It also forms a group generate/propagate pair. A second generator of the same design takes the group pairs and the adder carry-in and produces the carry into every group. The group carries therefore do not ripple from one group to the next. The lower generators then form the bit carries from them.

A single parameter `N` sets both the generator fan-in and the group count, so the operand width is `N*N`. The default `N = 4` gives a 16-bit adder built from four 4-bit groups and five identical generators. The block has no clock. Besides the sum and the carry-out, it drives the generate/propagate pair of the whole operand, so a wider lookahead level can use it.

Top module: `cla2_adder`

## Requirements
- R1: For every operand pair and carry-in, `{cout_o, sum_o}` equals `a_i + b_i + cin_i`, computed `N*N+1` bits wide.
- R2: `grp_prop_o` is 1 exactly when `a_i` and `b_i` differ in every bit position.
- R3: `grp_gen_o` is 1 exactly when `a_i + b_i`, with no carry-in, does not fit in `N*N` bits. `grp_gen_o` and `grp_prop_o` are never both 1.
- R4: `cout_o` equals `grp_gen_o OR (cin_i AND grp_prop_o)`.
- R5: When every bit position propagates (`a_i ^ b_i` all ones), the carry-in passes through every group. With `cin_i = 0` the sum is all ones and `cout_o = 0`. With `cin_i = 1` the sum is all zeros and `cout_o = 1`.
- R6: When every bit position generates (`a_i` and `b_i` both all ones), `cout_o = 1` whatever the carry-in. The sum is all ones, except that bit 0 equals `cin_i`.
- R7: A carry produced in bit 0 crosses every group boundary when all higher bits propagate. For example, `a_i = 1`, `b_i` all ones and `cin_i = 0` give a zero sum and `cout_o = 1`.
- R8: The outputs depend only on the present inputs, with no clock and no state. A new input value gives the matching result in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N*N | First operand |
| b_i | input | N*N | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | N*N | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |
| grp_gen_o | output | 1 | Generate of the whole operand |
| grp_prop_o | output | 1 | Propagate of the whole operand |

## Verification
The bench builds two copies of the adder. One uses `N = 2`, a 4-bit adder made of two 2-bit groups. Every operand pair and both carry-in values can be applied to it, so every carry path through both lookahead levels is covered, along with the group-pair outputs. The second copy uses the default `N = 4`. It receives random vectors and the all-propagate, all-generate and long-carry patterns, which test the 16-bit group boundaries at bits 4, 8 and 12.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Generate/propagate pair for a bit or a group of bits
    typedef struct packed {
        logic gen;
        logic prop;
    } gp_t;

endpackage

// File: rtl/cla_bit_gp.sv
module cla_bit_gp #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] prop_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign gen_o[i]  = a_i[i] & b_i[i];
        assign prop_o[i] = a_i[i] ^ b_i[i];
    end

endmodule

// File: rtl/cla_la_gen.sv
module cla_la_gen
    import cla_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    input  logic         cin_i,
    output logic [N-1:0] carry_o,   // carry_o[k] is the carry into position k; carry_o[0] is cin_i
    output gp_t          grp_o
);

    // gsum_d[k]: generate over positions [0,k-1]; psum_d[k]: propagate over the same span
    logic [N:0] gsum_d;
    logic [N:0] psum_d;

    always_comb begin
        logic term;
        logic acc;
        for (int k = 0; k <= N; k++) begin
            acc = 1'b0;
            for (int m = 0; m < k; m++) begin
                term = gen_i[m];
                for (int j = m + 1; j < k; j++) begin
                    term = term & prop_i[j];
                end
                acc = acc | term;
            end
            gsum_d[k] = acc;
            term = 1'b1;
            for (int j = 0; j < k; j++) begin
                term = term & prop_i[j];
            end
            psum_d[k] = term;
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_carry
        assign carry_o[k] = gsum_d[k] | (cin_i & psum_d[k]);
    end

    assign grp_o.gen  = gsum_d[N];
    assign grp_o.prop = psum_d[N];

    always_comb begin
        if (!$isunknown({gen_i, prop_i, cin_i})) begin
            // R5
            pass_through_chk: assert (!((&prop_i) && !(|gen_i)) || (carry_o == {N{cin_i}}))
                else $error("group carry did not follow carry-in under full propagate");
            // R3
            gp_exclusive_chk: assert (((gen_i & prop_i) != '0) || !(grp_o.gen && grp_o.prop))
                else $error("group generate and propagate both asserted");
        end
    end

endmodule

// File: rtl/cla2_adder.sv
module cla2_adder
    import cla_pkg::*;
#(
    parameter int N = 4,
    localparam int W = N * N
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         grp_gen_o,
    output logic         grp_prop_o
);

    logic [W-1:0] bit_gen;
    logic [W-1:0] bit_prop;
    logic [W-1:0] bit_carry;
    logic [N-1:0] blk_gen;
    logic [N-1:0] blk_prop;
    logic [N-1:0] blk_carry;
    gp_t          lo_gp [N];
    gp_t          top_gp;

    cla_bit_gp #(.W(W)) u_bit_gp (
        .a_i    (a_i),
        .b_i    (b_i),
        .gen_o  (bit_gen),
        .prop_o (bit_prop)
    );

    // Upper level: carry into every group from group pairs and the adder carry-in
    cla_la_gen #(.N(N)) u_hi (
        .gen_i   (blk_gen),
        .prop_i  (blk_prop),
        .cin_i   (cin_i),
        .carry_o (blk_carry),
        .grp_o   (top_gp)
    );

    // Lower level: one generator per group
    for (genvar grp = 0; grp < N; grp++) begin : g_grp
        cla_la_gen #(.N(N)) u_lo (
            .gen_i   (bit_gen[grp*N +: N]),
            .prop_i  (bit_prop[grp*N +: N]),
            .cin_i   (blk_carry[grp]),
            .carry_o (bit_carry[grp*N +: N]),
            .grp_o   (lo_gp[grp])
        );
        assign blk_gen[grp]  = lo_gp[grp].gen;
        assign blk_prop[grp] = lo_gp[grp].prop;
    end

    assign sum_o      = bit_prop ^ bit_carry;
    assign cout_o     = top_gp.gen | (cin_i & top_gp.prop);
    assign grp_gen_o  = top_gp.gen;
    assign grp_prop_o = top_gp.prop;

    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i})) begin
            // R1
            sum_match_chk: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
                else $error("sum does not match arithmetic addition");
            // R5
            prop_cout_chk: assert (!grp_prop_o || (cout_o == cin_i))
                else $error("carry-out differs from carry-in under full propagate");
            // R6
            all_gen_chk: assert (!((a_i & b_i) == {W{1'b1}}) || cout_o)
                else $error("no carry-out with every bit generating");
        end
    end

endmodule

// File: tb/tb_cla2_adder.sv
module tb_cla2_adder;

    localparam int NB = 4;
    localparam int WB = NB * NB;
    localparam int NS = 2;
    localparam int WS = NS * NS;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [WB-1:0] a_b, b_b, sum_b;
    logic          cin_b, cout_b, gg_b, gp_b;
    logic [WS-1:0] a_s, b_s, sum_s;
    logic          cin_s, cout_s, gg_s, gp_s;

    cla2_adder #(.N(NB)) dut (
        .a_i(a_b), .b_i(b_b), .cin_i(cin_b),
        .sum_o(sum_b), .cout_o(cout_b), .grp_gen_o(gg_b), .grp_prop_o(gp_b)
    );

    cla2_adder #(.N(NS)) dut_small (
        .a_i(a_s), .b_i(b_s), .cin_i(cin_s),
        .sum_o(sum_s), .cout_o(cout_s), .grp_gen_o(gg_s), .grp_prop_o(gp_s)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_big(input logic [WB-1:0] a, input logic [WB-1:0] b, input logic c);
        logic [WB:0] full;
        logic [WB:0] nocin;
        @(posedge clk);
        a_b = a; b_b = b; cin_b = c;
        @(negedge clk);
        full  = {1'b0, a} + {1'b0, b} + {{WB{1'b0}}, c};
        nocin = {1'b0, a} + {1'b0, b};
        chk("R1 sum", sum_b, full[WB-1:0]);
        chk("R1 cout", cout_b, full[WB]);
        chk("R2 grp_prop", gp_b, ((a ^ b) == {WB{1'b1}}));
        chk("R3 grp_gen", gg_b, nocin[WB]);
        chk("R4 cout form", cout_b, nocin[WB] | (c & ((a ^ b) == {WB{1'b1}})));
    endtask

    initial begin
        a_b = '0; b_b = '0; cin_b = 1'b0;
        a_s = '0; b_s = '0; cin_s = 1'b0;
        @(negedge clk);
        // R8: idle inputs give a zero result in the first cycle
        chk("R8 zero sum", sum_b, 0);
        chk("R8 zero cout", cout_b, 0);

        // R1, R2, R3, R4: exhaustive sweep of the 4-bit build
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int c = 0; c < 2; c++) begin
                    @(posedge clk);
                    a_s = a[WS-1:0]; b_s = b[WS-1:0]; cin_s = c[0];
                    @(negedge clk);
                    chk("R1 small sum", sum_s, (a + b + c) % 16);
                    chk("R1 small cout", cout_s, (a + b + c) / 16);
                    chk("R2 small prop", gp_s, ((a ^ b) == 15));
                    chk("R3 small gen", gg_s, ((a + b) >= 16));
                    chk("R3 small exclusive", gg_s & gp_s, 0);
                end
            end
        end

        // R5: all-propagate
        run_big(16'h5A5A, 16'hA5A5, 1'b0);
        chk("R5 prop sum", sum_b, 16'hFFFF);
        chk("R5 prop cout", cout_b, 0);
        run_big(16'h0F0F, 16'hF0F0, 1'b1);
        chk("R5 prop sum cin", sum_b, 16'h0000);
        chk("R5 prop cout cin", cout_b, 1);

        // R6: all-generate
        run_big(16'hFFFF, 16'hFFFF, 1'b0);
        chk("R6 gen sum", sum_b, 16'hFFFE);
        chk("R6 gen cout", cout_b, 1);
        run_big(16'hFFFF, 16'hFFFF, 1'b1);
        chk("R6 gen sum cin", sum_b, 16'hFFFF);
        chk("R6 gen cout cin", cout_b, 1);

        // R7: carry from bit 0 across every group boundary
        run_big(16'h0001, 16'hFFFF, 1'b0);
        chk("R7 long sum", sum_b, 16'h0000);
        chk("R7 long cout", cout_b, 1);
        run_big(16'h0FFF, 16'h0001, 1'b0);
        chk("R7 into top group", sum_b, 16'h1000);
        run_big(16'h00F0, 16'h0010, 1'b0);
        chk("R7 into group 2", sum_b, 16'h0100);

        // R1: random vectors on the 16-bit build
        for (int i = 0; i < 2000; i++) begin
            run_big($urandom(), $urandom(), $urandom() & 1);
        end

        // R8: a new input changes the result in the same cycle
        run_big(16'h1234, 16'h1111, 1'b0);
        chk("R8 follow", sum_b, 16'h2345);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule